// File: doc/BRIEF.md
# Legacy SMRAM Window Gate

This block holds a one-byte system-management RAM control register and, from it, steers every memory access that falls in the 128 KB legacy video range, 0xA0000 through 0xBFFFF. An access in that range goes either to the hidden DRAM behind the window or to the normal PCI/video path. The choice depends on the register bits and on a live input from the CPU that says whether it is running in system management mode. A lock bit freezes the security-relevant fields until the next reset.

Configuration writes arrive as plain byte writes, with an offset and data. Reads are combinational on the read offset. Memory accesses form a stream: `acc_valid`/`acc_ready` in and `res_valid`/`res_ready` out, with one register stage between them. The block takes an access when `acc_valid` and `acc_ready` are both high. `acc_ready` is high whenever the result stage is empty or is being drained in the same cycle. While `res_ready` is low, a pending result and its fields hold steady. The routing is worked out from the register contents and the mode input as they are in the cycle the access is taken. A change of either therefore affects the next access accepted, and no explicit update step is needed.

Top module: `smm_window_gate`

## Requirements
- R1: After reset the control byte at offset 0x9D reads 0x02, every field is clear, and every window access goes to PCI.
- R2: Writes to any offset other than 0x9D leave the control byte unchanged, and reads of any other offset return 0x00.
- R3: Bits 2:0 of the control byte always read 3'b010 and ignore writes. Bit 7 always reads 0.
- R4: With the global enable (bit 3) clear, every access in the window returns res_dram=0, meaning PCI.
- R5: With the global enable set and the mode input low, an access (code or data) goes to DRAM (res_dram=1) exactly when the open bit (bit 6) is set.
- R6: With the global enable set and the mode input high, a code fetch (acc_code=1) goes to DRAM. A data access goes to DRAM unless the close bit (bit 5) is set.
- R7: With open and close both set, a code fetch goes to DRAM while a data access made in system management mode goes to PCI.
- R8: A write that sets the lock bit (bit 4) clears the open bit in the same write. While lock is set, the open, lock and global-enable bits keep their values, the close bit stays writable, and only reset clears the lock.
- R9: The window is the aligned 128 KB range 0xA0000 to 0xBFFFF. For an access outside it, res_hit=0 and res_dram=0. For an access inside it, res_hit=1.
- R10: A change of the mode input alone, with no register write, changes the routing of the next accepted access.
- R11: A result appears with res_valid one cycle after its access is accepted. acc_ready = !res_valid || res_ready. While res_valid=1 and res_ready=0, the result fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_addr | input | CFG_AW | Configuration write offset |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_addr | input | CFG_AW | Configuration read offset |
| cfg_rd_data | output | 8 | Configuration read data (combinational) |
| smm_active | input | 1 | CPU is in system management mode |
| acc_valid | input | 1 | Memory access offered |
| acc_ready | output | 1 | Access accepted this cycle when valid |
| acc_addr | input | ADDR_W | Access address |
| acc_code | input | 1 | 1 = code fetch, 0 = data access |
| res_valid | output | 1 | Routing result available |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Access fell inside the window |
| res_dram | output | 1 | 1 = hidden DRAM, 0 = PCI path |

## Verification
The bench probes addresses one byte on each side of both window edges. A window compare that is off by one bit or by one segment would then claim 0x9FFFF or 0xC0000, or drop 0xBFFFF. It sets open and close together and sends both code and data in each mode, so a design that lets one bit dominate for both access types misroutes one of the four cases. It writes lock together with open, and later tries to reopen and disable the window. A design that keeps open, or lets a locked field change, would expose SMRAM outside system management mode. Stalling the result port checks that the held result is not overwritten by a second access waiting at the input.

// File: rtl/smw_pkg.sv
package smw_pkg;

  // Field positions inside the control byte (decoded by software).
  localparam int unsigned BIT_OPEN  = 6;
  localparam int unsigned BIT_CLOSE = 5;
  localparam int unsigned BIT_LOCK  = 4;
  localparam int unsigned BIT_GEN   = 3;

  // Hardwired segment code in the low three bits.
  localparam logic [2:0] SEG_CODE = 3'b010;

  typedef struct packed {
    logic open;
    logic close;
    logic lock;
    logic gen;
  } smw_ctl_t;

  typedef struct packed {
    logic hit;
    logic dram;
  } smw_route_t;

endpackage

// File: rtl/smw_ctl_reg.sv
module smw_ctl_reg
  import smw_pkg::*;
#(
  parameter int unsigned CFG_AW     = 8,
  parameter logic [CFG_AW-1:0] CTL_OFFSET = 8'h9D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [CFG_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output smw_ctl_t          ctl
);

  logic     sel_wr;
  smw_ctl_t ctl_q;

  assign sel_wr = wr_en && (wr_addr == CTL_OFFSET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (sel_wr) begin
      // close stays writable regardless of lock
      ctl_q.close <= wr_data[BIT_CLOSE];
      if (!ctl_q.lock) begin
        ctl_q.lock <= wr_data[BIT_LOCK];
        ctl_q.gen  <= wr_data[BIT_GEN];
        // a write that sets lock forces open low in the same write
        ctl_q.open <= wr_data[BIT_OPEN] & ~wr_data[BIT_LOCK];
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == CTL_OFFSET) begin
      rd_data[BIT_OPEN]  = ctl_q.open;
      rd_data[BIT_CLOSE] = ctl_q.close;
      rd_data[BIT_LOCK]  = ctl_q.lock;
      rd_data[BIT_GEN]   = ctl_q.gen;
      rd_data[2:0]       = SEG_CODE;
    end
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/smw_route.sv
module smw_route
  import smw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_code,
  input  logic              smm,
  input  smw_ctl_t          ctl,
  output smw_route_t        route
);

  localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic in_win;
  logic code_dram;
  logic data_dram;

  assign in_win = (addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);

  // Code: either mode or open exposes DRAM; open wins over close.
  assign code_dram = smm | ctl.open;
  // Data: in SMM close diverts to PCI; outside SMM only open matters.
  assign data_dram = smm ? ~ctl.close : ctl.open;

  always_comb begin
    route.hit  = in_win;
    route.dram = in_win & ctl.gen & (is_code ? code_dram : data_dram);
  end

endmodule

// File: rtl/smw_resp_stage.sv
module smw_resp_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/smm_window_gate.sv
module smm_window_gate
  import smw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned WIN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h000A_0000,
  parameter logic [CFG_AW-1:0] CTL_OFFSET = 8'h9D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [7:0]        cfg_wr_data,
  input  logic [CFG_AW-1:0] cfg_rd_addr,
  output logic [7:0]        cfg_rd_data,
  input  logic              smm_active,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_code,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic              res_dram
);

  localparam int unsigned RW = $bits(smw_route_t);

  smw_ctl_t   ctl_q;
  smw_route_t route_d;
  smw_route_t route_q;

  smw_ctl_reg #(
    .CFG_AW     (CFG_AW),
    .CTL_OFFSET (CTL_OFFSET)
  ) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .rd_addr (cfg_rd_addr),
    .rd_data (cfg_rd_data),
    .ctl     (ctl_q)
  );

  smw_route #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .WIN_BASE (WIN_BASE)
  ) u_route (
    .addr    (acc_addr),
    .is_code (acc_code),
    .smm     (smm_active),
    .ctl     (ctl_q),
    .route   (route_d)
  );

  smw_resp_stage #(
    .W (RW)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (acc_valid),
    .in_ready  (acc_ready),
    .in_data   (route_d),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (route_q)
  );

  assign res_hit  = route_q.hit;
  assign res_dram = route_q.dram;

endmodule

// File: rtl/smw_checker.sv
module smw_checker
  import smw_pkg::*;
#(
  parameter int unsigned CFG_AW = 8,
  parameter logic [CFG_AW-1:0] CTL_OFFSET = 8'h9D
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_AW-1:0] cfg_rd_addr,
  input logic [7:0]        cfg_rd_data,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic              res_dram,
  input smw_ctl_t          ctl
);

  assert_seg_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_addr == CTL_OFFSET) |-> (cfg_rd_data[2:0] == SEG_CODE && !cfg_rd_data[7]));

  assert_other_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_addr != CTL_OFFSET) |-> (cfg_rd_data == 8'h00));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.lock |=> ctl.lock);

  assert_lock_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.lock |=> ($stable(ctl.open) && $stable(ctl.gen)));

  assert_lock_clears_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.lock) |-> !ctl.open);

  assert_gen_off_pci_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !ctl.gen) |=> !res_dram);

  assert_outside_pci_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> !res_dram);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_dram)));

  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid || res_ready) |-> acc_ready);

endmodule

bind smm_window_gate smw_checker #(
  .CFG_AW     (CFG_AW),
  .CTL_OFFSET (CTL_OFFSET)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rd_addr (cfg_rd_addr),
  .cfg_rd_data (cfg_rd_data),
  .acc_valid   (acc_valid),
  .acc_ready   (acc_ready),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_hit     (res_hit),
  .res_dram    (res_dram),
  .ctl         (ctl_q)
);

// File: tb/tb_smm_window_gate.sv
module tb_smm_window_gate;

  localparam int PERIOD = 10;
  localparam logic [7:0] OFF = 8'h9D;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_addr;
  logic [7:0]  cfg_wr_data;
  logic [7:0]  cfg_rd_addr;
  logic [7:0]  cfg_rd_data;
  logic        smm_active;
  logic        acc_valid;
  logic        acc_ready;
  logic [31:0] acc_addr;
  logic        acc_code;
  logic        res_valid;
  logic        res_ready;
  logic        res_hit;
  logic        res_dram;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(PERIOD/2) clk = ~clk;

  smm_window_gate dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .smm_active(smm_active),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_code(acc_code),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_dram(res_dram)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(string req, logic [7:0] a, logic [7:0] exp);
    cfg_rd_addr = a;
    #1;
    chk(req, {24'h0, cfg_rd_data}, {24'h0, exp});
  endtask

  // One accepted access; checks the result the cycle after acceptance.
  task automatic access(string req, logic [31:0] a, logic code, logic smm,
                        logic exp_hit, logic exp_dram);
    @(negedge clk);
    res_ready = 1'b1;
    acc_valid = 1'b1; acc_addr = a; acc_code = code; smm_active = smm;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " valid"}, {31'h0, res_valid}, 32'h1);
    chk({req, " hit"},   {31'h0, res_hit},   {31'h0, exp_hit});
    chk({req, " dram"},  {31'h0, res_dram},  {31'h0, exp_dram});
  endtask

  task automatic t_reset();
    do_reset();
    cfg_read("R1 reset value", OFF, 8'h02);
    chk("R11 idle no result", {31'h0, res_valid}, 32'h0);
    access("R1 reset smm code", 32'h000A_0000, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_offsets();
    cfg_write(8'h9C, 8'h48);
    cfg_write(8'h9E, 8'h48);
    cfg_read("R2 other offset write ignored", OFF, 8'h02);
    cfg_read("R2 other offset reads zero", 8'h9E, 8'h00);
    cfg_write(OFF, 8'hFD);
    // FD: bit7 dropped, open+lock -> open cleared, close/lock/gen set, low bits 010
    cfg_read("R3 fixed bits", OFF, 8'h3A);
    do_reset();
    cfg_write(OFF, 8'h05);
    cfg_read("R3 low bits ignore writes", OFF, 8'h02);
  endtask

  task automatic t_gen_off();
    cfg_write(OFF, 8'h40);  // open, no enable
    access("R4 open without enable", 32'h000B_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    access("R4 smm without enable",  32'h000A_1234, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_non_smm();
    cfg_write(OFF, 8'h08);
    access("R5 closed code",  32'h000A_8000, 1'b1, 1'b0, 1'b1, 1'b0);
    access("R5 closed data",  32'h000A_8000, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg_write(OFF, 8'h48);
    access("R5 open code",    32'h000A_8000, 1'b1, 1'b0, 1'b1, 1'b1);
    access("R5 open data",    32'h000B_F000, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_smm();
    cfg_write(OFF, 8'h08);
    access("R6 smm code",        32'h000A_0000, 1'b1, 1'b1, 1'b1, 1'b1);
    access("R6 smm data",        32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b1);
    access("R10 mode drop data", 32'h000A_0000, 1'b0, 1'b0, 1'b1, 1'b0);
    access("R10 mode back data", 32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b1);
    cfg_write(OFF, 8'h28);
    access("R6 smm data close",  32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    access("R6 smm code close",  32'h000A_0000, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_both();
    cfg_write(OFF, 8'h68);
    access("R7 code smm",     32'h000A_4000, 1'b1, 1'b1, 1'b1, 1'b1);
    access("R7 data smm",     32'h000A_4000, 1'b0, 1'b1, 1'b1, 1'b0);
    access("R7 code non-smm", 32'h000A_4000, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_bounds();
    cfg_write(OFF, 8'h48);
    access("R9 below window", 32'h0009_FFFF, 1'b1, 1'b1, 1'b0, 1'b0);
    access("R9 first byte",   32'h000A_0000, 1'b1, 1'b0, 1'b1, 1'b1);
    access("R9 last byte",    32'h000B_FFFF, 1'b0, 1'b0, 1'b1, 1'b1);
    access("R9 above window", 32'h000C_0000, 1'b1, 1'b1, 1'b0, 1'b0);
    access("R9 high alias",   32'h100A_0000, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_lock();
    do_reset();
    cfg_write(OFF, 8'h48);
    cfg_read("R8 open before lock", OFF, 8'h4A);
    cfg_write(OFF, 8'h58);
    cfg_read("R8 lock clears open", OFF, 8'h1A);
    access("R8 locked non-smm", 32'h000A_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    cfg_write(OFF, 8'h60);
    cfg_read("R8 frozen fields, close writable", OFF, 8'h3A);
    access("R8 locked smm data close", 32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b0);
    cfg_write(OFF, 8'h00);
    cfg_read("R8 lock holds", OFF, 8'h1A);
    access("R8 enable still on", 32'h000A_0000, 1'b0, 1'b1, 1'b1, 1'b1);
    do_reset();
    cfg_read("R8 reset clears lock", OFF, 8'h02);
  endtask

  task automatic t_backpressure();
    cfg_write(OFF, 8'h48);
    @(negedge clk);
    res_ready = 1'b0;
    acc_valid = 1'b1; acc_addr = 32'h000A_0000; acc_code = 1'b1; smm_active = 1'b0;
    @(negedge clk);
    acc_addr = 32'h000C_0000;  // second access waits
    chk("R11 first result", {30'h0, res_valid, res_dram}, 32'h3);
    chk("R11 stalled not ready", {31'h0, acc_ready}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    chk("R11 held result", {29'h0, res_valid, res_hit, res_dram}, 32'h7);
    res_ready = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R11 second result", {29'h0, res_valid, res_hit, res_dram}, 32'h4);
    @(negedge clk);
    chk("R11 drained", {31'h0, res_valid}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
    cfg_rd_addr = OFF; smm_active = 1'b0; acc_valid = 1'b0; acc_addr = '0;
    acc_code = 1'b0; res_ready = 1'b1;
    t_reset();
    t_offsets();
    t_gen_off();
    t_non_smm();
    t_smm();
    t_both();
    t_bounds();
    t_lock();
    t_backpressure();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule